// File: doc/BRIEF.md
# Bit-Oriented Message Link Codec

This block carries short coded messages over the overhead data link of a framed serial line. The framer gives it one bit slot per link strobe. On the transmit side it sends a 16-bit pattern over and over. The pattern is a run of eight ones, then a message byte. The byte has a zero at each end and a 6-bit code from the host in the middle. On the receive side it searches the incoming bits for that flag run and captures the byte that follows. It then votes on the captured codes before it hands one to the host.

A received code is committed to the host-visible register only when it fills at least 7 of the last 10 captured message slots. This vote filters out bit errors on the line. When a code different from the held one is committed, the block pulses an interrupt, which the host can mask. One enable input gates both directions. The framer, the strobe generation and the host bus decode sit outside the block.

Top module: `bom_link_codec`

## Requirements
- R1: While enabled, `tx_bit_o` presents one bit per slot and advances only on a cycle where `strobe_i` is high. Starting from the slot after enable, each 16-slot frame is eight 1s, then 0, then code bits 5 down to 0 of the latched transmit code, then 0.
- R2: `tx_code_i` is latched into the transmitter only at a frame boundary, or at any time while disabled. A change made in the middle of a frame first appears in the next frame.
- R3: While `enable_i` is low, `tx_bit_o` is 1. Received bits are ignored, so `rx_code_o` and `irq_o` do not change.
- R4: The receiver locks after at least eight consecutive 1s followed by a 0. It then takes the next 7 bits: six code bits, most significant first, and a final bit. Only a final bit of 0 makes the slot a valid candidate. A final bit of 1 still occupies a history slot, but it matches nothing.
- R5: `rx_code_o` (reset value 0) loads a candidate code only when, counting the new slot, at least 7 of the last 10 slots hold that same valid code.
- R6: A load of a code that differs from the held code, or the first load after reset, raises `irq_o` for exactly one cycle.
- R7: When the voted code equals the code already held, there is no reload and no interrupt.
- R8: With `irq_mask_i` high at the time of the load, the code still loads but `irq_o` stays low.
- R9: After reset, `tx_bit_o` is 1, `rx_code_o` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Message link enable |
| strobe_i | input | 1 | One-cycle data-link bit strobe |
| tx_code_i | input | 6 | Host transmit code |
| tx_bit_o | output | 1 | Serial transmit bit for the current slot |
| rx_bit_i | input | 1 | Serial receive bit, sampled on strobe |
| rx_code_o | output | 6 | Last committed receive code |
| irq_mask_i | input | 1 | 1 suppresses the new-message interrupt |
| irq_o | output | 1 | New-message interrupt pulse |

## Verification
The assertions check several properties on every cycle:
- the transmit line idles high while disabled;
- the transmit bit holds between strobes;
- the receive register changes only right after a captured candidate;
- the interrupt is a single-cycle pulse that follows a candidate and never follows a set mask.

Some behaviours can only be shown by the bench's scenarios:
- the exact frame bit order;
- the code switch at the frame boundary;
- the 7-of-10 vote threshold, including interleaved and corrupted slots;
- the absence of an interrupt on a repeated code.

The bench shows these by comparing against a slot-level model under directed and random frame sequences.

// File: rtl/bom_pkg.sv
package bom_pkg;
  localparam int CODE_W = 6;

  typedef struct packed {
    logic              vld;
    logic [CODE_W-1:0] code;
  } slot_t;
endpackage

// File: rtl/bom_tx.sv
module bom_tx #(
  parameter int FLAG_LEN = 8,
  parameter int CODE_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              stb_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              bit_o
);
  localparam int FRAME_LEN = FLAG_LEN + CODE_W + 2;
  localparam int POS_W     = $clog2(FRAME_LEN);

  logic [POS_W-1:0]  pos_q;
  logic [CODE_W-1:0] code_q;
  logic [POS_W-1:0]  idx;
  logic [CODE_W-1:0] shifted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      code_q <= '0;
    end else if (!en_i) begin
      pos_q  <= '0;
      code_q <= code_i;
    end else if (stb_i) begin
      if (pos_q == POS_W'(FRAME_LEN - 1)) begin
        pos_q  <= '0;
        code_q <= code_i;  // new code only at frame boundary
      end else begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  assign idx     = POS_W'(FRAME_LEN - 2) - pos_q;
  assign shifted = code_q >> idx;

  always_comb begin
    if (!en_i)                               bit_o = 1'b1;
    else if (pos_q < POS_W'(FLAG_LEN))       bit_o = 1'b1;
    else if (pos_q == POS_W'(FLAG_LEN) ||
             pos_q == POS_W'(FRAME_LEN - 1)) bit_o = 1'b0;
    else                                     bit_o = shifted[0];
  end
endmodule

// File: rtl/bom_rx_deframer.sv
module bom_rx_deframer
  import bom_pkg::*;
#(
  parameter int FLAG_LEN = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  stb_i,
  input  logic  bit_i,
  output logic  cand_stb_o,
  output slot_t cand_o
);
  localparam int ONES_W = $clog2(FLAG_LEN + 1);
  localparam int CNT_W  = $clog2(CODE_W + 1);

  typedef enum logic {ST_HUNT, ST_CAPT} st_e;

  st_e               st_q;
  logic [ONES_W-1:0] ones_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_HUNT;
      ones_q     <= '0;
      cnt_q      <= '0;
      sh_q       <= '0;
      cand_stb_o <= 1'b0;
      cand_o     <= '0;
    end else begin
      cand_stb_o <= 1'b0;
      if (!en_i) begin
        st_q   <= ST_HUNT;
        ones_q <= '0;
        cnt_q  <= '0;
      end else if (stb_i) begin
        unique case (st_q)
          ST_HUNT: begin
            if (bit_i) begin
              if (ones_q != ONES_W'(FLAG_LEN)) ones_q <= ones_q + ONES_W'(1);
            end else begin
              if (ones_q == ONES_W'(FLAG_LEN)) begin
                st_q  <= ST_CAPT;
                cnt_q <= '0;
              end
              ones_q <= '0;
            end
          end
          ST_CAPT: begin
            if (cnt_q == CNT_W'(CODE_W)) begin
              // final framing bit: must be zero for a valid candidate
              cand_stb_o  <= 1'b1;
              cand_o.vld  <= ~bit_i;
              cand_o.code <= sh_q;
              st_q        <= ST_HUNT;
              ones_q      <= '0;
            end else begin
              sh_q  <= {sh_q[CODE_W-2:0], bit_i};
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: st_q <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/bom_rx_validator.sv
module bom_rx_validator
  import bom_pkg::*;
#(
  parameter int HIST_DEPTH = 10,
  parameter int MATCH_MIN  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_stb_i,
  input  slot_t             cand_i,
  input  logic              irq_mask_i,
  output logic [CODE_W-1:0] code_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(HIST_DEPTH + 1);

  slot_t                 hist_q [HIST_DEPTH];
  slot_t                 hist_d [HIST_DEPTH];
  logic [HIST_DEPTH-1:0] match;
  logic [CNT_W-1:0]      hits;
  logic                  held_q;
  logic                  accept;

  assign hist_d[0] = cand_i;

  for (genvar i = 1; i < HIST_DEPTH; i++) begin : g_shift
    assign hist_d[i] = hist_q[i-1];
  end

  for (genvar i = 0; i < HIST_DEPTH; i++) begin : g_match
    assign match[i] = cand_i.vld && hist_d[i].vld && (hist_d[i].code == cand_i.code);
  end

  always_comb begin
    hits = '0;
    for (int i = 0; i < HIST_DEPTH; i++) hits = hits + CNT_W'(match[i]);
  end

  assign accept = cand_stb_i && (hits >= CNT_W'(MATCH_MIN)) &&
                  (!held_q || (cand_i.code != code_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < HIST_DEPTH; i++) hist_q[i] <= '0;
      code_o <= '0;
      held_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (cand_stb_i) begin
        for (int i = 0; i < HIST_DEPTH; i++) hist_q[i] <= hist_d[i];
      end
      if (accept) begin
        code_o <= cand_i.code;
        held_q <= 1'b1;
        irq_o  <= ~irq_mask_i;
      end
    end
  end
endmodule

// File: rtl/bom_link_codec.sv
module bom_link_codec
  import bom_pkg::*;
#(
  parameter int FLAG_LEN   = 8,
  parameter int HIST_DEPTH = 10,
  parameter int MATCH_MIN  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              strobe_i,
  input  logic [CODE_W-1:0] tx_code_i,
  output logic              tx_bit_o,
  input  logic              rx_bit_i,
  output logic [CODE_W-1:0] rx_code_o,
  input  logic              irq_mask_i,
  output logic              irq_o
);
  logic  cand_stb;
  slot_t cand;

  bom_tx #(.FLAG_LEN(FLAG_LEN), .CODE_W(CODE_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (enable_i),
    .stb_i  (strobe_i),
    .code_i (tx_code_i),
    .bit_o  (tx_bit_o)
  );

  bom_rx_deframer #(.FLAG_LEN(FLAG_LEN)) u_deframer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (enable_i),
    .stb_i      (strobe_i),
    .bit_i      (rx_bit_i),
    .cand_stb_o (cand_stb),
    .cand_o     (cand)
  );

  bom_rx_validator #(.HIST_DEPTH(HIST_DEPTH), .MATCH_MIN(MATCH_MIN)) u_validator (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cand_stb_i (cand_stb),
    .cand_i     (cand),
    .irq_mask_i (irq_mask_i),
    .code_o     (rx_code_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/bom_link_codec_chk.sv
module bom_link_codec_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              strobe_i,
  input logic              tx_bit_o,
  input logic [CODE_W-1:0] rx_code_o,
  input logic              irq_mask_i,
  input logic              irq_o,
  input logic              cand_stb_i
);
  p_idle_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> tx_bit_o);

  p_tx_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && $past(enable_i) && !$past(strobe_i)) |-> $stable(tx_bit_o));

  p_load_after_cand_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cand_stb_i) |-> $stable(rx_code_o));

  p_irq_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(cand_stb_i));

  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(irq_mask_i));
endmodule

bind bom_link_codec bom_link_codec_chk #(.CODE_W(bom_pkg::CODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .strobe_i   (strobe_i),
  .tx_bit_o   (tx_bit_o),
  .rx_code_o  (rx_code_o),
  .irq_mask_i (irq_mask_i),
  .irq_o      (irq_o),
  .cand_stb_i (cand_stb)
);

// File: tb/bom_link_codec_tb_top.sv
module bom_link_codec_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       strobe = 1'b0;
  logic [5:0] tx_code = '0;
  logic       tx_bit;
  logic       rx_bit = 1'b1;
  logic [5:0] rx_code;
  logic       irq_mask = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  bit done = 0;

  // slot-level receive model
  bit         m_vld [10];
  logic [5:0] m_code [10];
  logic [5:0] m_held = '0;
  bit         m_held_vld = 0;
  int         m_irq = 0;

  always #2 clk = ~clk;

  bom_link_codec dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .enable_i   (enable),
    .strobe_i   (strobe),
    .tx_code_i  (tx_code),
    .tx_bit_o   (tx_bit),
    .rx_bit_i   (rx_bit),
    .rx_code_o  (rx_code),
    .irq_mask_i (irq_mask),
    .irq_o      (irq)
  );

  always @(posedge clk) if (rst_n && irq) irq_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic exp_tx(input int p, input logic [5:0] c);
    if (p < 8) return 1'b1;
    if (p == 8 || p == 15) return 1'b0;
    return c[14-p];
  endfunction

  task automatic slot(input logic rb, output logic tb);
    @(negedge clk);
    strobe = 1'b1;
    rx_bit = rb;
    tb = tx_bit;
    @(negedge clk);
    strobe = 1'b0;
    rx_bit = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic model_push(input bit vld, input logic [5:0] c);
    int hits = 0;
    for (int i = 9; i > 0; i--) begin
      m_vld[i]  = m_vld[i-1];
      m_code[i] = m_code[i-1];
    end
    m_vld[0] = vld;
    m_code[0] = c;
    if (vld) for (int i = 0; i < 10; i++) if (m_vld[i] && m_code[i] == c) hits++;
    if (vld && hits >= 7 && (!m_held_vld || c != m_held)) begin
      m_held = c;
      m_held_vld = 1;
      if (!irq_mask) m_irq++;
    end
  endtask

  task automatic send_frame(input logic [5:0] c, input bit bad, input bit counted);
    logic tb;
    for (int i = 0; i < 8; i++) slot(1'b1, tb);
    slot(1'b0, tb);
    for (int i = 5; i >= 0; i--) slot(c[i], tb);
    slot(bad, tb);
    if (counted) model_push(!bad, c);
  endtask

  task automatic check_rx(input string req);
    check(rx_code === m_held, {req, " rx_code"}, int'(rx_code), int'(m_held));
    check(irq_cnt == m_irq, {req, " irq count"}, irq_cnt, m_irq);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic tb;
    logic [5:0] codes [4];
    void'($urandom(32'h5eed_b0b1));
    for (int i = 0; i < 10; i++) begin m_vld[i] = 0; m_code[i] = '0; end

    repeat (3) @(negedge clk);
    // R9: reset values
    check(tx_bit === 1'b1, "R9 tx_bit", int'(tx_bit), 1);
    check(rx_code === 6'd0, "R9 rx_code", int'(rx_code), 0);
    check(irq === 1'b0, "R9 irq", int'(irq), 0);
    rst_n = 1'b1;

    // R3: disabled transmit idles high
    tx_code = 6'h2D;
    for (int i = 0; i < 16; i++) begin
      slot(1'b1, tb);
      check(tb === 1'b1, "R3 idle tx", int'(tb), 1);
    end

    // R1/R2: frame pattern, mid-frame code change
    @(negedge clk);
    enable = 1'b1;
    for (int s = 0; s < 48; s++) begin
      logic [5:0] ec;
      if (s == 20) tx_code = 6'h12;
      ec = (s < 32) ? 6'h2D : 6'h12;
      slot(1'b1, tb);
      check(tb === exp_tx(s % 16, ec), (s >= 16 && s < 32) ? "R2 tx bit" : "R1 tx bit",
            int'(tb), int'(exp_tx(s % 16, ec)));
    end

    // R3: receive ignored while disabled
    @(negedge clk);
    enable = 1'b0;
    for (int f = 0; f < 10; f++) send_frame(6'h33, 0, 0);
    check_rx("R3 disabled rx");
    @(negedge clk);
    enable = 1'b1;

    // R5: six frames are not enough, the seventh loads
    for (int f = 0; f < 6; f++) send_frame(6'h15, 0, 1);
    check(rx_code === 6'd0, "R5 below threshold", int'(rx_code), 0);
    check_rx("R5 six frames");
    send_frame(6'h15, 0, 1);
    check(rx_code === 6'h15, "R5 seventh frame", int'(rx_code), 'h15);
    check(irq_cnt == 1, "R6 first irq", irq_cnt, 1);

    // R7: repeats of the held code
    for (int f = 0; f < 4; f++) send_frame(6'h15, 0, 1);
    check(irq_cnt == 1, "R7 no repeat irq", irq_cnt, 1);
    check_rx("R7 repeat");

    // R5: interleaved slots, 7 of 10
    send_frame(6'h2A, 0, 1); send_frame(6'h2A, 0, 1); send_frame(6'h0C, 0, 1);
    send_frame(6'h2A, 0, 1); send_frame(6'h2A, 1, 1); send_frame(6'h2A, 0, 1);
    send_frame(6'h2A, 0, 1); send_frame(6'h2A, 0, 1);
    check_rx("R5 interleaved six");
    send_frame(6'h2A, 0, 1);
    check(rx_code === 6'h2A, "R5 interleaved load", int'(rx_code), 'h2A);
    check_rx("R6 interleaved");

    // R8: masked load
    irq_mask = 1'b1;
    for (int f = 0; f < 7; f++) send_frame(6'h07, 0, 1);
    check(rx_code === 6'h07, "R8 masked load", int'(rx_code), 'h07);
    check_rx("R8 masked irq");
    irq_mask = 1'b0;

    // R4: bad final bit never counts
    for (int f = 0; f < 10; f++) send_frame(6'h38, 1, 1);
    check(rx_code === 6'h07, "R4 bad final bit", int'(rx_code), 'h07);
    check_rx("R4 bad frames");

    // random frame mix
    codes[0] = 6'h00; codes[1] = 6'h15; codes[2] = 6'h3C; codes[3] = 6'h21;
    for (int f = 0; f < 90; f++) begin
      logic [5:0] c = codes[$urandom_range(0, 1) == 0 ? 0 : $urandom_range(0, 3)];
      bit bad = ($urandom_range(0, 9) == 0);
      irq_mask = ($urandom_range(0, 4) == 0);
      send_frame(c, bad, 1);
      check_rx("R5 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule